// File: doc/BRIEF.md
# Tagged Token Wait-Match Unit

This block sits in a tagged-token dataflow pipeline. It pairs the operand tokens of two-input instructions. Every token carries a context (frame) identifier, an instruction address, a port bit that selects the left or the right operand, a single-operand flag and a data value. The lookup key is the pair of context and instruction address. Many loop iterations or calls can therefore run through one shared copy of the code, each under its own context, without their operands mixing.

An incoming two-input token is compared against every valid entry of a small fully associative waiting table.

- **Hit:** the partner leaves the table in the same cycle. Both operands go out together on the next cycle, with the left-port value always on the left output.
- **Miss:** the token takes the lowest free entry and a bubble goes out in its slot.
- **Single-operand token:** it bypasses the table entirely.
- **Full table:** if the table is full and a two-input token would miss, the unit holds off its producer by dropping input ready.

Every accepted token produces exactly one registered output one cycle later, tagged with a result kind.

Top module: `token_match_unit`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1 and the waiting table holds no token.
- R2: A token with in_single=1 is accepted regardless of table occupancy. One cycle later it appears with out_kind=2 (single), out_left equal to its data and out_right equal to 0. The table is left unchanged.
- R3: A two-input token whose key (context, address) matches no valid entry is written into a free entry. One cycle later out_kind=0 (bubble), with out_left and out_right both 0.
- R4: A match requires both the context identifier and the instruction address to be equal. Equal address under another context, or equal context at another address, is a miss. At most one entry ever matches.
- R5: When a token meets a waiting partner of the opposite port, one cycle later out_kind=1 (pair). out_left carries the value that arrived on port 0 (left) and out_right the value from port 1 (right), whatever the arrival order.
- R6: A pair frees its entry in the same cycle. A later token with the same key misses again.
- R7: A token that finds a waiting entry with the same key and the same port is reported with out_kind=3 (error). out_left holds the incoming data and out_right the stored data. The incoming token is dropped and the stored entry is kept.
- R8: While all DEPTH entries are valid, a two-input token that misses sees in_ready=0 and is not accepted (no output next cycle). Hitting and single-operand tokens are still accepted.
- R9: The table holds up to DEPTH tokens. Freeing an entry by a pair lets a previously blocked miss be accepted.
- R10: Each accepted token (in_valid and in_ready high at a clock edge) gives exactly one cycle with out_valid=1 after that edge. out_ctx and out_addr echo the token's key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming token present |
| in_ready | output | 1 | Token will be accepted this cycle |
| in_ctx | input | CTX_W | Context (frame) identifier |
| in_addr | input | ADDR_W | Instruction address |
| in_port | input | 1 | Operand side: 0 left, 1 right |
| in_single | input | 1 | Token belongs to a one-input instruction |
| in_data | input | DATA_W | Operand value |
| out_valid | output | 1 | Result slot holds an output |
| out_kind | output | 2 | 0 bubble, 1 pair, 2 single, 3 error |
| out_ctx | output | CTX_W | Context of the token that produced the slot |
| out_addr | output | ADDR_W | Instruction address of that token |
| out_left | output | DATA_W | Left operand (or incoming data) |
| out_right | output | DATA_W | Right operand (or stored data) |

## Verification
The following properties are checked on every cycle:

- one output per accepted token;
- single-operand pass-through;
- at most one associative hit;
- in_ready dropping only when the table is full;
- table occupancy rising by one on a bubble, falling by one on a pair, and holding steady on an error.

Only the bench scenarios can show the rest. These are the left/right ordering of paired operands under both arrival orders across a sweep of contexts and addresses, keys that differ in only one field, error reporting without loss of the waiting entry, and recovery from a full table after a pair frees space.

// File: rtl/wm_pkg.sv
package wm_pkg;

    typedef enum logic [1:0] {
        KIND_BUBBLE = 2'd0,
        KIND_PAIR   = 2'd1,
        KIND_SINGLE = 2'd2,
        KIND_ERROR  = 2'd3
    } out_kind_e;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    typedef enum logic [1:0] {
        ACT_PASS,
        ACT_STORE,
        ACT_PAIR,
        ACT_CLASH
    } action_e;

    function automatic action_e decide(input logic single, input logic hit,
                                       input logic same_side);
        if (single)
            return ACT_PASS;
        else if (!hit)
            return ACT_STORE;
        else if (same_side)
            return ACT_CLASH;
        else
            return ACT_PAIR;
    endfunction

    function automatic out_kind_e kind_of(input action_e act);
        case (act)
            ACT_PASS:  return KIND_SINGLE;
            ACT_STORE: return KIND_BUBBLE;
            ACT_PAIR:  return KIND_PAIR;
            default:   return KIND_ERROR;
        endcase
    endfunction

endpackage

// File: rtl/wm_free_alloc.sv
module wm_free_alloc #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] busy,
    output logic             free_any,
    output logic [IDX_W-1:0] free_idx
);

    logic [DEPTH-1:0] lower_free;

    // lower_free[i] is set when some entry below i is free
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_scan
            if (i == 0) begin : g_first
                assign lower_free[i] = 1'b0;
            end else begin : g_rest
                assign lower_free[i] = lower_free[i-1] | ~busy[i-1];
            end
        end
    endgenerate

    always_comb begin
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!busy[i] && !lower_free[i])
                free_idx = IDX_W'(i);
        end
    end

    assign free_any = ~&busy;

endmodule

// File: rtl/wm_key_cam.sv
module wm_key_cam #(
    parameter int DEPTH = 8,
    parameter int KEY_W = 12,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]            entry_valid,
    input  logic [DEPTH-1:0][KEY_W-1:0] entry_key,
    input  logic [KEY_W-1:0]            probe_key,
    output logic [DEPTH-1:0]            hit_vec,
    output logic                        hit_any,
    output logic [IDX_W-1:0]            hit_idx
);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
            assign hit_vec[i] = entry_valid[i] && (entry_key[i] == probe_key);
        end
    endgenerate

    // keys in the table are unique, so OR-ing indices yields the single hit
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i])
                hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit_any = |hit_vec;

endmodule

// File: rtl/wm_entry_store.sv
module wm_entry_store #(
    parameter int DEPTH  = 8,
    parameter int KEY_W  = 12,
    parameter int DATA_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [KEY_W-1:0]             wr_key,
    input  logic                         wr_side,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_idx,
    output logic [DEPTH-1:0]             valid_q,
    output logic [DEPTH-1:0][KEY_W-1:0]  key_q,
    output logic [DEPTH-1:0]             side_q,
    output logic [DEPTH-1:0][DATA_W-1:0] data_q
);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            logic wr_here;
            logic clr_here;
            assign wr_here  = wr_en  && (wr_idx  == IDX_W'(i));
            assign clr_here = clr_en && (clr_idx == IDX_W'(i));

            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q[i] <= 1'b0;
                    key_q[i]   <= '0;
                    side_q[i]  <= 1'b0;
                    data_q[i]  <= '0;
                end else if (wr_here) begin
                    valid_q[i] <= 1'b1;
                    key_q[i]   <= wr_key;
                    side_q[i]  <= wr_side;
                    data_q[i]  <= wr_data;
                end else if (clr_here) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/token_match_unit.sv
module token_match_unit
    import wm_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CTX_W  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CTX_W-1:0]  in_ctx,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_port,
    input  logic              in_single,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [CTX_W-1:0]  out_ctx,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);

    localparam int KEY_W = CTX_W + ADDR_W;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [CTX_W-1:0]  ctx;
        logic [ADDR_W-1:0] addr;
    } key_t;

    typedef struct packed {
        out_kind_e         kind;
        key_t              key;
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] right;
    } result_t;

    key_t                         probe;
    logic [DEPTH-1:0]             store_valid;
    logic [DEPTH-1:0][KEY_W-1:0]  store_key;
    logic [DEPTH-1:0]             store_side;
    logic [DEPTH-1:0][DATA_W-1:0] store_data;
    logic [DEPTH-1:0]             cam_hit;
    logic                         hit_any;
    logic [IDX_W-1:0]             hit_idx;
    logic                         free_any;
    logic [IDX_W-1:0]             free_idx;
    logic                         partner_side;
    logic [DATA_W-1:0]            partner_data;
    action_e                      act;
    logic                         accept;
    result_t                      res_d;
    result_t                      res_q;
    logic                         slot_q;

    assign probe = '{ctx: in_ctx, addr: in_addr};

    wm_key_cam #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_cam (
        .entry_valid (store_valid),
        .entry_key   (store_key),
        .probe_key   (probe),
        .hit_vec     (cam_hit),
        .hit_any     (hit_any),
        .hit_idx     (hit_idx)
    );

    wm_free_alloc #(.DEPTH(DEPTH)) u_alloc (
        .busy     (store_valid),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    assign partner_side = store_side[hit_idx];
    assign partner_data = store_data[hit_idx];

    assign act      = decide(in_single, hit_any, partner_side == in_port);
    assign in_ready = !(act == ACT_STORE && !free_any);
    assign accept   = in_valid && in_ready;

    wm_entry_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept && act == ACT_STORE),
        .wr_idx  (free_idx),
        .wr_key  (probe),
        .wr_side (in_port),
        .wr_data (in_data),
        .clr_en  (accept && act == ACT_PAIR),
        .clr_idx (hit_idx),
        .valid_q (store_valid),
        .key_q   (store_key),
        .side_q  (store_side),
        .data_q  (store_data)
    );

    always_comb begin
        res_d.kind  = kind_of(act);
        res_d.key   = probe;
        res_d.left  = '0;
        res_d.right = '0;
        case (act)
            ACT_PASS: begin
                res_d.left = in_data;
            end
            ACT_PAIR: begin
                if (in_port == SIDE_LEFT) begin
                    res_d.left  = in_data;
                    res_d.right = partner_data;
                end else begin
                    res_d.left  = partner_data;
                    res_d.right = in_data;
                end
            end
            ACT_CLASH: begin
                res_d.left  = in_data;
                res_d.right = partner_data;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= 1'b0;
            res_q  <= '0;
        end else begin
            slot_q <= accept;
            if (accept)
                res_q <= res_d;
        end
    end

    assign out_valid = slot_q;
    assign out_kind  = res_q.kind;
    assign out_ctx   = res_q.key.ctx;
    assign out_addr  = res_q.key.addr;
    assign out_left  = res_q.left;
    assign out_right = res_q.right;

endmodule

// File: rtl/wm_checker.sv
module wm_checker #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_single,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic [DEPTH-1:0]  valid_vec,
    input logic [DEPTH-1:0]  hit_vec
);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    AST_ONE_SLOT_PER_TOKEN: assert property (@(posedge clk) disable iff (rst || !seen)
        out_valid == $past(in_valid && in_ready)); // R10

    AST_SINGLE_BYPASS: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(in_valid && in_ready && in_single) |->
            (out_kind == 2'd2 && out_left == $past(in_data) && out_right == '0)); // R2

    AST_UNIQUE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R4

    AST_READY_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> ($countones(valid_vec) == DEPTH && !in_single)); // R8

    AST_BUBBLE_FILLS: assert property (@(posedge clk) disable iff (rst || !seen)
        (out_valid && out_kind == 2'd0) |->
            ($countones(valid_vec) == $countones($past(valid_vec)) + 1)); // R3

    AST_PAIR_FREES: assert property (@(posedge clk) disable iff (rst || !seen)
        (out_valid && out_kind == 2'd1) |->
            ($countones(valid_vec) + 1 == $countones($past(valid_vec)))); // R6

    AST_CLASH_KEEPS: assert property (@(posedge clk) disable iff (rst || !seen)
        (out_valid && out_kind == 2'd3) |-> $stable(valid_vec)); // R7

endmodule

bind token_match_unit wm_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_wm_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_single (in_single),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_left  (out_left),
    .out_right (out_right),
    .valid_vec (store_valid),
    .hit_vec   (cam_hit)
);

// File: tb/tb_token_match_unit.sv
module tb_token_match_unit;

    localparam int DEPTH  = 4;
    localparam int CTX_W  = 2;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    localparam int K_BUB = 0;
    localparam int K_PAIR = 1;
    localparam int K_SGL = 2;
    localparam int K_ERR = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [CTX_W-1:0]  in_ctx = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic              in_port = 1'b0;
    logic              in_single = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [1:0]        out_kind;
    logic [CTX_W-1:0]  out_ctx;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_left;
    logic [DATA_W-1:0] out_right;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    token_match_unit #(.DEPTH(DEPTH), .CTX_W(CTX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_ctx(in_ctx), .in_addr(in_addr), .in_port(in_port),
        .in_single(in_single), .in_data(in_data),
        .out_valid(out_valid), .out_kind(out_kind),
        .out_ctx(out_ctx), .out_addr(out_addr),
        .out_left(out_left), .out_right(out_right)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int c, input int a, input int p, input int s, input int d);
        in_ctx    = CTX_W'(c);
        in_addr   = ADDR_W'(a);
        in_port   = p[0];
        in_single = s[0];
        in_data   = DATA_W'(d);
        in_valid  = 1'b1;
    endtask

    // offer a token that must be accepted, then check its result slot
    task automatic send(input int c, input int a, input int p, input int s, input int d,
                        input int ek, input int el, input int er, input string tag);
        @(negedge clk);
        drive(c, a, p, s, d);
        #1;
        chk({tag, " in_ready"}, int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R10 out_valid"}, int'(out_valid), 1);
        chk({tag, " out_kind"}, int'(out_kind), ek);
        chk({tag, " out_left"}, int'(out_left), el);
        chk({tag, " out_right"}, int'(out_right), er);
        chk({tag, " R10 out_ctx"}, int'(out_ctx), c);
        chk({tag, " R10 out_addr"}, int'(out_addr), a);
    endtask

    // offer a token that must be refused
    task automatic blocked(input int c, input int a, input int p, input string tag);
        @(negedge clk);
        drive(c, a, p, 0, 16'hDEAD);
        #1;
        chk({tag, " in_ready low"}, int'(in_ready), 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " no slot"}, int'(out_valid), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);

        // sweep every key in both arrival orders
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 8; a++) begin
                for (int o = 0; o < 2; o++) begin
                    int d1 = (c * 64 + a * 8 + o * 3 + 5) & 16'hFFFF;
                    int d2 = d1 ^ 16'h5A00;
                    send(c, a, o, 0, d1, K_BUB, 0, 0, "R3 miss");
                    send(c, a, 1 - o, 0, d2, K_PAIR,
                         (o == 0) ? d1 : d2, (o == 0) ? d2 : d1, "R5 pair order");
                end
            end
        end

        // R6: freed entry misses again
        send(2, 6, 1, 0, 16'h0101, K_BUB, 0, 0, "R6 setup");
        send(2, 6, 0, 0, 16'h0202, K_PAIR, 16'h0202, 16'h0101, "R6 pair");
        send(2, 6, 0, 0, 16'h0303, K_BUB, 0, 0, "R6 misses after free");
        send(2, 6, 1, 0, 16'h0404, K_PAIR, 16'h0303, 16'h0404, "R6 cleanup");

        // R4: partial key equality is a miss
        send(1, 2, 0, 0, 11, K_BUB, 0, 0, "R4 store");
        send(2, 2, 1, 0, 22, K_BUB, 0, 0, "R4 other ctx");
        send(1, 3, 1, 0, 33, K_BUB, 0, 0, "R4 other addr");
        send(1, 2, 1, 0, 44, K_PAIR, 11, 44, "R4 full key");
        send(2, 2, 0, 0, 55, K_PAIR, 55, 22, "R4 cleanup a");
        send(1, 3, 0, 0, 66, K_PAIR, 66, 33, "R4 cleanup b");

        // R7: same port collision
        send(3, 5, 0, 0, 7, K_BUB, 0, 0, "R7 store");
        send(3, 5, 0, 0, 9, K_ERR, 9, 7, "R7 error");
        send(3, 5, 1, 0, 8, K_PAIR, 7, 8, "R7 entry kept");

        // R2: single operands, including with a waiting entry of same key
        send(0, 1, 1, 0, 16'h1111, K_BUB, 0, 0, "R2 setup");
        send(0, 1, 0, 1, 16'hBEEF, K_SGL, 16'hBEEF, 0, "R2 single");
        send(0, 1, 0, 0, 16'h2222, K_PAIR, 16'h2222, 16'h1111, "R2 table untouched");

        // R8 and R9: fill, block, bypass while full, free, accept
        for (int a = 0; a < DEPTH; a++)
            send(0, a, 0, 0, 16'h100 + a, K_BUB, 0, 0, "R9 fill");
        blocked(0, 4, 0, "R8 full miss");
        blocked(3, 0, 1, "R8 full other ctx");
        send(1, 7, 1, 1, 16'h7777, K_SGL, 16'h7777, 0, "R8 single while full");
        send(0, 3, 0, 0, 16'h0999, K_ERR, 16'h0999, 16'h103, "R8 clash while full");
        send(0, 2, 1, 0, 16'h0AAA, K_PAIR, 16'h102, 16'h0AAA, "R8 hit while full");
        send(0, 4, 0, 0, 16'h0BBB, K_BUB, 0, 0, "R9 accepted after free");
        blocked(0, 5, 1, "R9 full again");
        send(0, 0, 1, 0, 1, K_PAIR, 16'h100, 1, "R9 drain");
        send(0, 1, 1, 0, 2, K_PAIR, 16'h101, 2, "R9 drain");
        send(0, 3, 1, 0, 3, K_PAIR, 16'h103, 3, "R9 drain");
        send(0, 4, 1, 0, 4, K_PAIR, 16'h0BBB, 4, "R9 drain");

        @(negedge clk);
        chk("R10 idle after last token", int'(out_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule